// File: doc/BRIEF.md
# DDR Command Timing Checker

This block sits beside a DDR SDRAM command bus and watches it without driving anything back. On every rising edge of the memory clock it sees one decoded command, the bank it targets, the A10 address bit and the clock-enable level. From these it keeps, for each bank, whether a row is open and how many cycles have passed since that bank's last activate and last precharge. It also keeps global counters since the last activate to any bank, the last write, the last mode-register load and the last refresh. Every timing limit is a parameter in clock cycles.

When a command arrives too early, or a row stays open too long, the checker produces a one-cycle violation pulse and sets a sticky flag. The code and bank of the first violation are held until a clear input is asserted. A design team puts it in simulation or emulation next to a memory controller, to catch scheduling mistakes as soon as they happen.

Top module: `ddr_cmd_timing_mon`

## Requirements
- R1: After reset `viol`, `viol_flag`, `viol_code` and `viol_bank` are all 0, every bank is closed, and all timers count as long expired. Command encoding: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 REF, 6 LMR.
- R2: A RD or WR to an open bank fewer than T_RCD cycles after that bank's ACT gives code 1. A RD or WR with A10=1 (auto-precharge) whose cycle distance from ACT plus T_AP_DLY is below T_RAS gives code 11.
- R3: An ACT to a bank fewer than T_RP cycles after its explicit precharge gives code 2. After an auto-precharge the limit is T_RP+T_AP_DLY cycles. A REF while any bank is still within its precharge window also gives code 2, with the lowest such bank reported.
- R4: An ACT fewer than T_RRD cycles after an ACT to any bank gives code 3.
- R5: A PRE with A10=0 to a bank open for fewer than T_RAS cycles gives code 4. A PRE with A10=1 closes all banks and gives code 4 for the lowest open bank younger than T_RAS.
- R6: A bank still open T_RAS_MAX+1 cycles after its ACT gives code 5 on exactly that edge. A PRE at T_RAS_MAX cycles is legal.
- R7: An ACT to a bank fewer than T_RC cycles after its previous ACT gives code 6. So does a REF while any bank's last ACT is younger than T_RC, with the lowest such bank reported.
- R8: Any non-NOP command fewer than T_MRD cycles after an LMR gives code 7, with bank 0.
- R9: Any non-NOP command fewer than T_RFC cycles after a REF gives code 8, with bank 0. CKE low on the REF edge itself, or on any edge fewer than T_RFC cycles after it, gives code 9, with bank 0.
- R10: A RD T_WTR or fewer cycles after a WR to any bank gives code 10.
- R11: A RD or WR to a closed bank gives code 12. A PRE with A10=0 to a closed bank gives code 13. An ACT to an open bank gives code 14. A PRE with A10=1 while all banks are closed is legal.
- R12: `viol` is high for the one cycle after each violating edge. `viol_flag` rises with the first violation and stays high until `clr`. `viol_code` and `viol_bank` keep the first violation's values while the flag is set. A `clr` edge zeroes them, unless a violation occurs on that same edge, in which case that violation is latched.
- R13: When several rules fail on one edge, one code is reported, in this priority: 9, 8, 7, then 12, 13, 14, then 1, 11, 10, 4, 2, 6, 3, then 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Decoded command (R1 encoding) |
| bank | input | BA_W | Target bank |
| a10 | input | 1 | Auto-precharge on RD/WR, all-banks on PRE |
| cke | input | 1 | Clock enable level |
| clr | input | 1 | Clears the sticky flag, code and bank |
| viol | output | 1 | One-cycle pulse per violating edge |
| viol_flag | output | 1 | Sticky violation flag |
| viol_code | output | 4 | Code of the first violation |
| viol_bank | output | BA_W | Bank of the first violation |

## Verification
The hardest cases to reach are the rules that other rules hide. With the default limits, T_RC equals T_RAS plus T_RP, so the fastest legal ACT-PRE-ACT sequence always breaks the precharge rule first. The bench therefore widens T_RC, which leaves a window of gaps where only the row-cycle rule fails. The too-late row rule needs a bank held open for thousands of cycles, so T_RAS_MAX is reduced and the bench walks right up to the limit and one edge past it. Every timing rule is then swept across the gaps on both sides of its limit, with the expected code computed from the gap.

// File: rtl/ddr_cmd_timing_mon.sv
module ddr_cmd_timing_mon #(
  parameter int BA_W      = 2,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RAS_MAX = 16000,
  parameter int T_RC      = 8,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 10,
  parameter int T_WTR     = 1,
  parameter int T_AP_DLY  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cmd,
  input  logic [BA_W-1:0] bank,
  input  logic            a10,
  input  logic            cke,
  input  logic            clr,
  output logic            viol,
  output logic            viol_flag,
  output logic [3:0]      viol_code,
  output logic [BA_W-1:0] viol_bank
);
  localparam int NB = 1 << BA_W;
  localparam int CW = $clog2(T_RAS_MAX + 3);
  localparam logic [CW-1:0] SAT    = {CW{1'b1}};
  localparam logic [CW-1:0] C_RCD  = CW'(T_RCD);
  localparam logic [CW-1:0] C_RP   = CW'(T_RP);
  localparam logic [CW-1:0] C_RPAP = CW'(T_RP + T_AP_DLY);
  localparam logic [CW-1:0] C_RRD  = CW'(T_RRD);
  localparam logic [CW-1:0] C_RAS  = CW'(T_RAS);
  localparam logic [CW-1:0] C_APL  = CW'((T_RAS > T_AP_DLY) ? T_RAS - T_AP_DLY : 0);
  localparam logic [CW-1:0] C_RMX1 = CW'(T_RAS_MAX + 1);
  localparam logic [CW-1:0] C_RC   = CW'(T_RC);
  localparam logic [CW-1:0] C_MRD  = CW'(T_MRD);
  localparam logic [CW-1:0] C_RFC  = CW'(T_RFC);
  localparam logic [CW-1:0] C_WTR  = CW'(T_WTR);

  localparam logic [2:0] K_ACT = 3'd1, K_RD = 3'd2, K_WR = 3'd3,
                         K_PRE = 3'd4, K_REF = 3'd5, K_LMR = 3'd6;

  logic [NB-1:0] open_q, ap_q;
  logic [CW-1:0] act_age [NB];
  logic [CW-1:0] pre_age [NB];
  logic [CW-1:0] any_act, wr_age, lmr_age, ref_age;

  logic          flag_q, viol_q;
  logic [3:0]    code_q, code_n;
  logic [BA_W-1:0] bank_q, bank_n;

  wire is_act = cmd == K_ACT;
  wire is_rd  = cmd == K_RD;
  wire is_wr  = cmd == K_WR;
  wire is_pre = cmd == K_PRE;
  wire is_ref = cmd == K_REF;
  wire is_lmr = cmd == K_LMR;
  wire is_cmd = cmd != 3'd0;
  wire is_rw  = is_rd | is_wr;

  wire          s_open = open_q[bank];
  wire [CW-1:0] s_act  = act_age[bank];
  wire [CW-1:0] s_pre  = pre_age[bank];
  wire [CW-1:0] s_need = ap_q[bank] ? C_RPAP : C_RP;

  logic [NB-1:0] rasmax_v, rasmin_v, refrp_v, refrc_v;

  function automatic logic [CW-1:0] inc(input logic [CW-1:0] x);
    return (x == SAT) ? x : x + 1'b1;
  endfunction

  function automatic logic [BA_W-1:0] lowest(input logic [NB-1:0] v);
    logic [BA_W-1:0] r;
    r = '0;
    for (int i = NB - 1; i >= 0; i--)
      if (v[i]) r = BA_W'(i);
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      rasmax_v[i] = open_q[i] && (act_age[i] == C_RMX1);
      rasmin_v[i] = open_q[i] && (act_age[i] < C_RAS);
      refrp_v[i]  = pre_age[i] < (ap_q[i] ? C_RPAP : C_RP);
      refrc_v[i]  = act_age[i] < C_RC;
    end
  end

  always_comb begin
    code_n = 4'd0;
    bank_n = '0;
    if (!cke && (is_ref || ref_age < C_RFC))            code_n = 4'd9;
    else if (is_cmd && ref_age < C_RFC)                 code_n = 4'd8;
    else if (is_cmd && lmr_age < C_MRD)                 code_n = 4'd7;
    else if (is_rw && !s_open)                          begin code_n = 4'd12; bank_n = bank; end
    else if (is_pre && !a10 && !s_open)                 begin code_n = 4'd13; bank_n = bank; end
    else if (is_act && s_open)                          begin code_n = 4'd14; bank_n = bank; end
    else if (is_rw && s_act < C_RCD)                    begin code_n = 4'd1;  bank_n = bank; end
    else if (is_rw && a10 && s_act < C_APL)             begin code_n = 4'd11; bank_n = bank; end
    else if (is_rd && wr_age <= C_WTR)                  begin code_n = 4'd10; bank_n = bank; end
    else if (is_pre && !a10 && s_act < C_RAS)           begin code_n = 4'd4;  bank_n = bank; end
    else if (is_pre && a10 && |rasmin_v)                begin code_n = 4'd4;  bank_n = lowest(rasmin_v); end
    else if (is_act && s_pre < s_need)                  begin code_n = 4'd2;  bank_n = bank; end
    else if (is_act && s_act < C_RC)                    begin code_n = 4'd6;  bank_n = bank; end
    else if (is_act && any_act < C_RRD)                 begin code_n = 4'd3;  bank_n = bank; end
    else if (is_ref && |refrp_v)                        begin code_n = 4'd2;  bank_n = lowest(refrp_v); end
    else if (is_ref && |refrc_v)                        begin code_n = 4'd6;  bank_n = lowest(refrc_v); end
    else if (|rasmax_v)                                 begin code_n = 4'd5;  bank_n = lowest(rasmax_v); end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      ap_q   <= '0;
      for (int i = 0; i < NB; i++) begin
        act_age[i] <= SAT;
        pre_age[i] <= SAT;
      end
    end else begin
      for (int i = 0; i < NB; i++) begin
        act_age[i] <= inc(act_age[i]);
        pre_age[i] <= inc(pre_age[i]);
        if (is_act && bank == BA_W'(i)) begin
          open_q[i]  <= 1'b1;
          act_age[i] <= CW'(1);
        end
        if (is_pre && (a10 || bank == BA_W'(i))) begin
          open_q[i]  <= 1'b0;
          pre_age[i] <= CW'(1);
          ap_q[i]    <= 1'b0;
        end
        if (is_rw && a10 && bank == BA_W'(i)) begin
          open_q[i]  <= 1'b0;
          pre_age[i] <= CW'(1);
          ap_q[i]    <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_act <= SAT;
      wr_age  <= SAT;
      lmr_age <= SAT;
      ref_age <= SAT;
    end else begin
      any_act <= is_act ? CW'(1) : inc(any_act);
      wr_age  <= is_wr  ? CW'(1) : inc(wr_age);
      lmr_age <= is_lmr ? CW'(1) : inc(lmr_age);
      ref_age <= is_ref ? CW'(1) : inc(ref_age);
    end
  end

  wire hit = code_n != 4'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      flag_q <= 1'b0;
      code_q <= 4'd0;
      bank_q <= '0;
    end else begin
      viol_q <= hit;
      flag_q <= hit | (flag_q & ~clr);
      if (hit && (!flag_q || clr)) begin
        code_q <= code_n;
        bank_q <= bank_n;
      end else if (clr) begin
        code_q <= 4'd0;
        bank_q <= '0;
      end
    end
  end

  assign viol      = viol_q;
  assign viol_flag = flag_q;
  assign viol_code = code_q;
  assign viol_bank = bank_q;

  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr |=> flag_q);

  // R12
  first_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr |=> $stable(code_q) && $stable(bank_q));

  // R12
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> flag_q);

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q |-> (code_q == 4'd0) && (bank_q == '0));

  // R3
  rp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_n == 4'd2) |-> (is_act || is_ref));

  // R9
  cke_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_n == 4'd9) |-> !cke);
endmodule

// File: tb/sim_ddr_cmd_timing_mon.sv
`timescale 1ns/1ps
module sim_ddr_cmd_timing_mon;
  localparam int RCD = 2, RP = 2, RRD = 2, RAS = 6, RMX = 30, RC = 10,
                 MRD = 2, RFC = 10, WTR = 1, APD = 2;
  localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, REF = 5, LMR = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd = NOP;
  logic [1:0] bank = 2'd0;
  logic a10 = 1'b0, cke = 1'b1, clr = 1'b0;
  logic viol, viol_flag;
  logic [3:0] viol_code;
  logic [1:0] viol_bank;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ddr_cmd_timing_mon #(.BA_W(2), .T_RCD(RCD), .T_RP(RP), .T_RRD(RRD), .T_RAS(RAS),
    .T_RAS_MAX(RMX), .T_RC(RC), .T_MRD(MRD), .T_RFC(RFC), .T_WTR(WTR),
    .T_AP_DLY(APD)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .a10(a10), .cke(cke),
    .clr(clr), .viol(viol), .viol_flag(viol_flag), .viol_code(viol_code),
    .viol_bank(viol_bank));

  task automatic cyc(input logic [2:0] c, input int b, input bit ap);
    cmd = c; bank = 2'(b); a10 = ap;
    @(negedge clk);
  endtask

  task automatic nops(input int n);
    for (int k = 0; k < n; k++) cyc(NOP, 0, 0);
  endtask

  task automatic do_rst;
    rst_n = 1'b0; cmd = NOP; clr = 1'b0; cke = 1'b1; a10 = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk(input string r, input int ecode, input int ebank);
    int eb;
    eb = (ecode == 0) ? 0 : ebank;
    checks++;
    if (viol_flag !== (ecode != 0) || viol_code !== 4'(ecode) || viol_bank !== 2'(eb)) begin
      errors++;
      $display("FAIL %s: flag=%0b code=%0d bank=%0d expected flag=%0b code=%0d bank=%0d",
               r, viol_flag, viol_code, viol_bank, ecode != 0, ecode, eb);
    end
  endtask

  task automatic chk_pulse(input string r, input bit e);
    checks++;
    if (viol !== e) begin
      errors++;
      $display("FAIL %s: viol=%0b expected %0b", r, viol, e);
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL R1 watchdog: run still active, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_rst;
    chk("R1 reset", 0, 0);
    chk_pulse("R1 reset pulse", 1'b0);

    // R2: RCD sweep, reads and writes, every bank
    for (int b = 0; b < 4; b++)
      for (int d = 1; d <= 4; d++)
        for (int w = 0; w < 2; w++) begin
          do_rst; cyc(ACT, b, 0); nops(d - 1); cyc(w ? WR : RD, b, 0);
          chk("R2 rcd", (d < RCD) ? 1 : 0, b);
        end
    // R2: auto-precharge vs minimum row time
    for (int d = 2; d <= 8; d++)
      for (int w = 0; w < 2; w++) begin
        do_rst; cyc(ACT, 1, 0); nops(d - 1); cyc(w ? WR : RD, 1, 1);
        chk("R2 ap_ras", (d + APD < RAS) ? 11 : 0, 1);
      end
    // R5: explicit precharge sweep
    for (int b = 0; b < 4; b++)
      for (int d = 1; d <= 8; d++) begin
        do_rst; cyc(ACT, b, 0); nops(d - 1); cyc(PRE, b, 0);
        chk("R5 ras_min", (d < RAS) ? 4 : 0, b);
      end
    // R5: precharge-all names lowest young bank
    do_rst; cyc(ACT, 3, 0); nops(1); cyc(ACT, 2, 0); nops(2); cyc(PRE, 0, 1);
    chk("R5 pre_all", 4, 2);
    // R3 and R7: ACT after precharge, sweep across both windows
    for (int dp = 1; dp <= 5; dp++) begin
      do_rst; cyc(ACT, 2, 0); nops(RAS - 1); cyc(PRE, 2, 0); nops(dp - 1); cyc(ACT, 2, 0);
      chk("R3/R7 act", (dp < RP) ? 2 : ((RAS + dp < RC) ? 6 : 0), 2);
    end
    // R3 and R7: REF after precharge
    for (int dp = 1; dp <= 5; dp++) begin
      do_rst; cyc(ACT, 3, 0); nops(RAS - 1); cyc(PRE, 3, 0); nops(dp - 1); cyc(REF, 0, 0);
      chk("R3/R7 ref", (dp < RP) ? 2 : ((RAS + dp < RC) ? 6 : 0), 3);
    end
    // R3: longer precharge need after auto-precharge
    for (int dp = 1; dp <= 5; dp++) begin
      do_rst; cyc(ACT, 0, 0); nops(RAS - APD - 1); cyc(RD, 0, 1); nops(dp - 1); cyc(ACT, 0, 0);
      chk("R3 ap_rp", (dp < RP + APD) ? 2 : ((RAS - APD + dp < RC) ? 6 : 0), 0);
    end
    // R4: activate spacing across banks
    for (int d = 1; d <= 3; d++) begin
      do_rst; cyc(ACT, 0, 0); nops(d - 1); cyc(ACT, 1, 0);
      chk("R4 rrd", (d < RRD) ? 3 : 0, 1);
    end
    // R6: too late precharge
    do_rst; cyc(ACT, 1, 0); nops(RMX - 1); cyc(PRE, 1, 0);
    chk("R6 pre_at_limit", 0, 0);
    do_rst; cyc(ACT, 1, 0); nops(RMX);
    chk("R6 before_limit", 0, 0);
    nops(1);
    chk("R6 ras_max", 5, 1);
    // R8: mode load spacing
    for (int d = 1; d <= 3; d++) begin
      do_rst; cyc(LMR, 0, 0); nops(d - 1); cyc(ACT, 2, 0);
      chk("R8 mrd", (d < MRD) ? 7 : 0, 0);
    end
    // R9: refresh command spacing
    for (int d = 1; d <= 11; d++) begin
      do_rst; cyc(REF, 0, 0); nops(d - 1); cyc(ACT, 1, 0);
      chk("R9 rfc", (d < RFC) ? 8 : 0, 0);
    end
    // R9: clock enable held during refresh
    for (int d = 0; d <= 11; d++) begin
      do_rst;
      if (d == 0) begin cke = 1'b0; cyc(REF, 0, 0); end
      else begin cyc(REF, 0, 0); nops(d - 1); cke = 1'b0; cyc(NOP, 0, 0); end
      cke = 1'b1;
      chk("R9 cke", (d < RFC) ? 9 : 0, 0);
    end
    // R10: write to read
    for (int d = 1; d <= 3; d++) begin
      do_rst; cyc(ACT, 2, 0); nops(RCD - 1); cyc(WR, 2, 0); nops(d - 1); cyc(RD, 2, 0);
      chk("R10 wtr", (d <= WTR) ? 10 : 0, 2);
    end
    // R11: protocol errors
    do_rst; cyc(RD, 3, 0);  chk("R11 rd_closed", 12, 3);
    do_rst; cyc(WR, 1, 0);  chk("R11 wr_closed", 12, 1);
    do_rst; cyc(PRE, 2, 0); chk("R11 pre_closed", 13, 2);
    do_rst; cyc(PRE, 2, 1); chk("R11 pre_all_idle", 0, 0);
    do_rst; cyc(ACT, 0, 0); nops(RC); cyc(ACT, 0, 0); chk("R11 act_open", 14, 0);
    // R12: sticky behaviour
    do_rst; cyc(ACT, 0, 0); cyc(ACT, 1, 0);
    chk("R12 first", 3, 1); chk_pulse("R12 pulse", 1'b1);
    nops(1);
    chk("R12 held", 3, 1); chk_pulse("R12 pulse_end", 1'b0);
    cyc(RD, 3, 0);
    chk("R12 second_ignored", 3, 1); chk_pulse("R12 pulse_again", 1'b1);
    clr = 1'b1; cyc(NOP, 0, 0); clr = 1'b0;
    chk("R12 cleared", 0, 0);
    cyc(RD, 3, 0);
    chk("R12 relatch", 12, 3);
    clr = 1'b1; cyc(WR, 2, 0); clr = 1'b0;
    chk("R12 clr_and_hit", 12, 2);
    // R13: priority
    do_rst; cyc(LMR, 0, 0); cyc(RD, 1, 0);
    chk("R13 mrd_over_closed", 7, 0);
    do_rst; cyc(REF, 0, 0); cke = 1'b0; cyc(ACT, 1, 0); cke = 1'b1;
    chk("R13 cke_over_rfc", 9, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule